// File: doc/BRIEF.md
# Multi-Phase Instruction Step Sequencer

This block is the hardwired control core of a multi-cycle processor. It walks each instruction through an ordered chain of up to six major phases: fetch, address calculation, indirect address read, operand read, execute and result store. Each phase is split into a short, parameterised run of minor steps, one microoperation per step. The instruction class is given as four descriptor flags. Phases the instruction does not need are skipped, so only fetch and execute are visited by every instruction.

The descriptor enters through a valid/ready handshake. `start` is the valid and `start_ready` is the ready. `start_ready` is high only while the sequencer is idle. A descriptor is captured on a cycle where both are high. While busy, `start_ready` is low and `start` and the descriptor are ignored, so the source must hold its request until the sequencer returns to idle.

Memory-touching steps wait on `mem_ready`. The current major phase and minor step drive the datapath through `major_state`, `minor_step` and the one-hot `phase_strobe`. `instr_done` pulses once for each finished instruction.

Top module: `phase_seq`

## Requirements
- R1: A synchronous reset, active high on `rst`, leaves the block idle in the next cycle with `major_state`=0 (fetch), `minor_step`=0, `phase_strobe`=0, `start_ready`=1 and `instr_done`=0. This also applies in the middle of an instruction.
- R2: `start_ready` is 1 exactly while idle. When `start` and `start_ready` are both 1 at a clock edge, the descriptor is latched and the next cycle shows fetch, step 0, with `start_ready`=0. While idle with `start`=0 the outputs do not change. While busy, `start` and the descriptor inputs have no effect on the running sequence.
- R3: The phase codes are fetch=0, address calculation=1, indirect=2, operand read=3, execute=4 and store=5, and phases are visited in rising code order. Fetch and execute are always visited. Address calculation is visited if `desc_mem_ref` is set. Indirect is visited if `desc_mem_ref` and `desc_indirect` are set. Operand read is visited if `desc_mem_ref` and `desc_rd_opnd` are set. Store is visited if `desc_mem_ref` and `desc_wr_result` are set.
- R4: With `desc_mem_ref`=0, the flags `desc_indirect`, `desc_rd_opnd` and `desc_wr_result` have no effect, and the instruction visits only fetch then execute.
- R5: Each phase runs its minor steps 0, 1, …, N-1 in order, and the minor step restarts at 0 on every phase change. The default step counts N are fetch 2, address 1, indirect 2, operand read 2, execute 3 and store 2, each settable from 1 to 3.
- R6: The last minor step of fetch, indirect, operand read and store is a memory step. While `mem_ready` is 0 on a memory step, both the major phase and the minor step hold.
- R7: All other steps advance on every clock regardless of `mem_ready`.
- R8: After the last step of execute, or of store when store is used, the block returns to idle at fetch step 0. `instr_done` is high for exactly that one cycle.
- R9: While busy, `phase_strobe` has only bit `major_state` set. While idle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Descriptor valid |
| desc_mem_ref | input | 1 | Instruction references memory |
| desc_indirect | input | 1 | Operand address is read from memory |
| desc_rd_opnd | input | 1 | Operand is read from memory |
| desc_wr_result | input | 1 | Result is stored to memory |
| mem_ready | input | 1 | Memory access completes this cycle |
| start_ready | output | 1 | Descriptor ready (sequencer idle) |
| major_state | output | 3 | Current major phase code |
| minor_step | output | 2 | Current minor step within the phase |
| phase_strobe | output | 6 | One-hot current phase, zero when idle |
| instr_done | output | 1 | One-cycle pulse on instruction completion |

## Verification
Every cycle, the assertions check these local rules:
- stall holding on memory steps and unit advance on the other steps;
- the minor step restarting at zero on phase change and staying within the phase's count;
- fetch at step 0 right after a handshake;
- the single-cycle, idle-only completion pulse;
- the fetch/execute restriction when memory is not referenced.

Only the bench's scenarios can show the full phase chain for each of the sixteen descriptor combinations, including the skipping order. The same holds for immunity to descriptor noise while busy and for recovery from a reset in the middle of an instruction.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;

  typedef enum logic [2:0] {
    PH_IF  = 3'd0,
    PH_OAC = 3'd1,
    PH_IND = 3'd2,
    PH_OPF = 3'd3,
    PH_EXE = 3'd4,
    PH_OPS = 3'd5
  } phase_e;

  localparam int NUM_PHASES = 6;

  typedef struct packed {
    logic mem_ref;
    logic indirect;
    logic rd_opnd;
    logic wr_result;
  } ins_desc_t;

  function automatic logic is_mem_phase(phase_e p);
    return (p == PH_IF) || (p == PH_IND) || (p == PH_OPF) || (p == PH_OPS);
  endfunction

endpackage

// File: rtl/phase_step_cfg.sv
module phase_step_cfg
  import phase_seq_pkg::*;
#(
  parameter int MINOR_W   = 2,
  parameter int IF_STEPS  = 2,
  parameter int OAC_STEPS = 1,
  parameter int IND_STEPS = 2,
  parameter int OPF_STEPS = 2,
  parameter int EXE_STEPS = 3,
  parameter int OPS_STEPS = 2
) (
  input  phase_e               cur,
  input  logic [MINOR_W-1:0]   minor,
  output logic [MINOR_W-1:0]   last_idx,
  output logic                 last_step,
  output logic                 mem_step
);

  always_comb begin
    case (cur)
      PH_IF:   last_idx = MINOR_W'(IF_STEPS - 1);
      PH_OAC:  last_idx = MINOR_W'(OAC_STEPS - 1);
      PH_IND:  last_idx = MINOR_W'(IND_STEPS - 1);
      PH_OPF:  last_idx = MINOR_W'(OPF_STEPS - 1);
      PH_EXE:  last_idx = MINOR_W'(EXE_STEPS - 1);
      PH_OPS:  last_idx = MINOR_W'(OPS_STEPS - 1);
      default: last_idx = '0;
    endcase
  end

  assign last_step = (minor == last_idx);
  assign mem_step  = last_step && is_mem_phase(cur);

endmodule

// File: rtl/phase_next_sel.sv
module phase_next_sel
  import phase_seq_pkg::*;
(
  input  phase_e    cur,
  input  ins_desc_t desc,
  output phase_e    nxt,
  output logic      final_phase
);

  logic m, i, r, w;
  assign m = desc.mem_ref;
  assign i = desc.mem_ref & desc.indirect;
  assign r = desc.mem_ref & desc.rd_opnd;
  assign w = desc.mem_ref & desc.wr_result;

  always_comb begin
    nxt         = PH_EXE;
    final_phase = 1'b0;
    case (cur)
      PH_IF:  nxt = m ? PH_OAC : PH_EXE;
      PH_OAC: begin
        if (i)      nxt = PH_IND;
        else if (r) nxt = PH_OPF;
        else        nxt = PH_EXE;
      end
      PH_IND: nxt = r ? PH_OPF : PH_EXE;
      PH_OPF: nxt = PH_EXE;
      PH_EXE: begin
        if (w) nxt = PH_OPS;
        else begin
          nxt         = PH_IF;
          final_phase = 1'b1;
        end
      end
      default: begin
        nxt         = PH_IF;
        final_phase = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/phase_seq.sv
module phase_seq
  import phase_seq_pkg::*;
#(
  parameter int MAX_STEPS = 3,
  parameter int IF_STEPS  = 2,
  parameter int OAC_STEPS = 1,
  parameter int IND_STEPS = 2,
  parameter int OPF_STEPS = 2,
  parameter int EXE_STEPS = 3,
  parameter int OPS_STEPS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       desc_mem_ref,
  input  logic       desc_indirect,
  input  logic       desc_rd_opnd,
  input  logic       desc_wr_result,
  input  logic       mem_ready,
  output logic       start_ready,
  output logic [2:0] major_state,
  output logic [1:0] minor_step,
  output logic [5:0] phase_strobe,
  output logic       instr_done
);

  localparam int MINOR_W = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1;

  logic                busy;
  phase_e              major;
  logic [MINOR_W-1:0]  minor;
  ins_desc_t           desc_q;
  ins_desc_t           desc_in;
  logic                done_q;

  phase_e              nxt;
  logic                final_phase;
  logic [MINOR_W-1:0]  last_idx;
  logic                last_step;
  logic                mem_step;
  logic                adv;

  assign desc_in = '{mem_ref: desc_mem_ref, indirect: desc_indirect,
                     rd_opnd: desc_rd_opnd, wr_result: desc_wr_result};

  phase_step_cfg #(
    .MINOR_W(MINOR_W), .IF_STEPS(IF_STEPS), .OAC_STEPS(OAC_STEPS),
    .IND_STEPS(IND_STEPS), .OPF_STEPS(OPF_STEPS), .EXE_STEPS(EXE_STEPS),
    .OPS_STEPS(OPS_STEPS)
  ) cfg_i (
    .cur(major), .minor(minor), .last_idx(last_idx),
    .last_step(last_step), .mem_step(mem_step)
  );

  phase_next_sel next_i (
    .cur(major), .desc(desc_q), .nxt(nxt), .final_phase(final_phase)
  );

  assign adv = busy && (!mem_step || mem_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      major  <= PH_IF;
      minor  <= '0;
      desc_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          desc_q <= desc_in;
          major  <= PH_IF;
          minor  <= '0;
        end
      end else if (adv) begin
        if (last_step) begin
          minor <= '0;
          if (final_phase) begin
            busy   <= 1'b0;
            major  <= PH_IF;
            done_q <= 1'b1;
          end else begin
            major <= nxt;
          end
        end else begin
          minor <= minor + 1'b1;
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_PHASES; g++) begin : g_strobe
      assign phase_strobe[g] = busy && (major == phase_e'(g));
    end
  endgenerate

  assign start_ready = !busy;
  assign major_state = major;
  assign minor_step  = 2'(minor);
  assign instr_done  = done_q;

  // R2: accepted descriptor starts at fetch step 0
  p_start_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && major == PH_IF && minor == '0));

  // R4: no memory phases when memory is not referenced
  p_skip_mem_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !desc_q.mem_ref) |-> (major == PH_IF || major == PH_EXE));

  // R5: minor restarts at zero after the last step of a phase
  p_minor_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (adv && last_step) |=> (minor == '0));

  // R5: minor stays inside the phase's step count
  p_minor_range_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (minor <= last_idx));

  // R6: memory step holds while memory is not ready
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && mem_step && !mem_ready) |=>
      (busy && major == $past(major) && minor == $past(minor)));

  // R7: non-memory, non-final steps advance by one
  p_step_adv_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !mem_step && !last_step) |=>
      (major == $past(major) && minor == $past(minor) + 1'b1));

  // R8: completion pulse lasts one cycle and lands in idle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    instr_done |=> !instr_done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    instr_done |-> (start_ready && major_state == 3'd0 && minor_step == 2'd0));

  // R9: strobe is one-hot while busy
  p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones(phase_strobe) == 1));

endmodule

// File: tb/phase_seq_tb_top.sv
module phase_seq_tb_top;

  localparam int S_IF = 2, S_OAC = 1, S_IND = 2, S_OPF = 2, S_EXE = 3, S_OPS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic d_m = 1'b0, d_i = 1'b0, d_r = 1'b0, d_w = 1'b0;
  logic mem_ready = 1'b0;
  logic       start_ready;
  logic [2:0] major_state;
  logic [1:0] minor_step;
  logic [5:0] phase_strobe;
  logic       instr_done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  int tr_maj [24];
  int tr_min [24];
  int tr_len;

  always #4 clk = ~clk;

  phase_seq #(
    .IF_STEPS(S_IF), .OAC_STEPS(S_OAC), .IND_STEPS(S_IND),
    .OPF_STEPS(S_OPF), .EXE_STEPS(S_EXE), .OPS_STEPS(S_OPS)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .desc_mem_ref(d_m), .desc_indirect(d_i), .desc_rd_opnd(d_r),
    .desc_wr_result(d_w), .mem_ready(mem_ready),
    .start_ready(start_ready), .major_state(major_state),
    .minor_step(minor_step), .phase_strobe(phase_strobe),
    .instr_done(instr_done)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int steps_of(int p);
    case (p)
      0: return S_IF;
      1: return S_OAC;
      2: return S_IND;
      3: return S_OPF;
      4: return S_EXE;
      default: return S_OPS;
    endcase
  endfunction

  function automatic bit is_mem_step(int p, int s);
    return (s == steps_of(p) - 1) && (p == 0 || p == 2 || p == 3 || p == 5);
  endfunction

  task automatic build_trace(bit m, bit i, bit r, bit w);
    bit use_ph [6];
    use_ph[0] = 1'b1;
    use_ph[1] = m;
    use_ph[2] = m & i;
    use_ph[3] = m & r;
    use_ph[4] = 1'b1;
    use_ph[5] = m & w;
    tr_len = 0;
    for (int p = 0; p < 6; p++) begin
      if (use_ph[p]) begin
        for (int s = 0; s < steps_of(p); s++) begin
          tr_maj[tr_len] = p;
          tr_min[tr_len] = s;
          tr_len++;
        end
      end
    end
  endtask

  task automatic check_idle(string req);
    check_eq(req, "major", int'(major_state), 0);
    check_eq(req, "minor", int'(minor_step), 0);
    check_eq(req, "strobe", int'(phase_strobe), 0);
    check_eq(req, "start_ready", int'(start_ready), 1);
  endtask

  // Called at a negedge while idle; returns at the negedge after done.
  task automatic run_instr(bit m, bit i, bit r, bit w, int stall_pct, bit noise);
    int idx;
    string mtag;
    string stag;
    check_eq("R2", "start_ready before start", int'(start_ready), 1);
    start = 1'b1; d_m = m; d_i = i; d_r = r; d_w = w;
    mem_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    build_trace(m, i, r, w);
    idx  = 0;
    stag = "R2";
    mtag = m ? "R3" : "R4";
    while (idx < tr_len) begin
      check_eq(mtag, "major", int'(major_state), tr_maj[idx]);
      check_eq(stag, "minor", int'(minor_step), tr_min[idx]);
      check_eq("R9", "strobe", int'(phase_strobe), 1 << tr_maj[idx]);
      check_eq("R2", "start_ready busy", int'(start_ready), 0);
      check_eq("R8", "done while busy", int'(instr_done), 0);
      mem_ready = ($urandom_range(99) >= stall_pct);
      if (noise) begin
        start = $urandom_range(1);
        d_m = $urandom_range(1); d_i = $urandom_range(1);
        d_r = $urandom_range(1); d_w = $urandom_range(1);
      end
      if (is_mem_step(tr_maj[idx], tr_min[idx])) begin
        stag = "R6";
        if (mem_ready) idx++;
      end else begin
        stag = "R7";
        idx++;
      end
      if (idx < tr_len && tr_min[idx] == 0 && stag == "R7") stag = "R5";
      @(negedge clk);
    end
    start = 1'b0;
    check_eq("R8", "done pulse", int'(instr_done), 1);
    check_idle("R8");
    @(negedge clk);
    check_eq("R8", "done one cycle", int'(instr_done), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check_idle("R1");
    check_eq("R1", "done", int'(instr_done), 0);

    // R2: idle hold with start low
    for (int k = 0; k < 5; k++) begin
      mem_ready = $urandom_range(1);
      d_m = $urandom_range(1);
      @(negedge clk);
      check_idle("R2");
    end

    // Directed: every descriptor combination, no stalls then heavy stalls
    for (int c = 0; c < 16; c++) begin
      run_instr(c[3], c[2], c[1], c[0], 0, 1'b0);
    end
    for (int c = 0; c < 16; c++) begin
      run_instr(c[3], c[2], c[1], c[0], 80, 1'b1);
    end

    // R1: reset in the middle of an instruction
    start = 1'b1; d_m = 1'b1; d_i = 1'b1; d_r = 1'b1; d_w = 1'b1;
    mem_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_idle("R1");
    check_eq("R1", "done after reset", int'(instr_done), 0);

    // Random mix with descriptor noise while busy
    for (int n = 0; n < 300; n++) begin
      run_instr($urandom_range(1), $urandom_range(1), $urandom_range(1),
                $urandom_range(1), $urandom_range(60), 1'b1);
      if ($urandom_range(3) == 0) begin
        @(negedge clk);
        check_idle("R2");
      end
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule